// File: doc/BRIEF.md
# Next-Instruction Address Unit

This unit owns the program counter of a simple single-issue processor and works out, on every clock edge, which instruction address comes next. It exposes the current address to drive instruction fetch, together with that address plus four. The instruction's 16-bit immediate and 26-bit jump field come from decode. A branch-select and a jump-select come from the main control. The equality flag comes from the ALU comparison.

Three candidate addresses are formed in parallel. The first is the sequential address. The second is a branch target: the sequential address plus the sign-extended immediate scaled by four. The third is a region-relative jump: the top four bits of the sequential address, the 26-bit jump field, and two zero bits. A small selector picks one of three named sources (SRC_SEQ, SRC_BRANCH, SRC_JUMP). The counter register loads the chosen address unconditionally at each rising edge. A synchronous reset loads a configurable start address instead. There is no state machine beyond the counter register itself. The source choice is a purely combinational decision made afresh each cycle.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter loads `START_ADDR` (default 0) and stays there for as long as reset is held, whatever the other inputs are.
- R2: `pc_plus4_o` always equals `pc_o + 4` modulo 2^32.
- R3: With `jmp_sel_i` low and either `br_sel_i` low or `alu_eq_i` low, the counter advances to `pc_o + 4` at the next edge. When `br_sel_i` is low, `alu_eq_i` has no effect.
- R4: With `jmp_sel_i` low, `br_sel_i` high and `alu_eq_i` high, the next counter value is `pc_o + 4 + (sign_extend(imm_i) << 2)`. Bit 15 of `imm_i` is the sign bit.
- R5: With `br_sel_i` high but `alu_eq_i` low, the branch is not taken and the counter advances by 4.
- R6: With `jmp_sel_i` high, the next counter value is `{pc_plus4_o[31:28], jtgt_i[25:0], 2'b00}`. The region bits come from the incremented address, not from the current one.
- R7: When `jmp_sel_i` and a taken branch occur together, the jump wins.
- R8: All address arithmetic wraps modulo 2^32. A negative immediate moves the counter backward, and stepping past 0xFFFFFFFC returns to 0.
- R9: The two lowest counter bits are zero after reset and after every update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imm_i | input | 16 | Branch displacement in words, two's complement |
| jtgt_i | input | 26 | Jump field, word address within the current 256 MiB region |
| br_sel_i | input | 1 | Branch instruction in execution |
| jmp_sel_i | input | 1 | Jump instruction in execution |
| alu_eq_i | input | 1 | Operands compared equal |
| pc_o | output | 32 | Current instruction address |
| pc_plus4_o | output | 32 | Current address plus four |

## Verification
The bound checker watches every cycle for the following properties:
- reset loading and holding the start address;
- sequential advance when no taken branch or jump is requested;
- taken-branch arithmetic;
- jump assembly, including jump priority over a simultaneous taken branch;
- word alignment of the counter.

Some behaviours depend on particular values and only the bench's directed scenarios show them:
- wrap-around of the counter past the top of the address space;
- a backward branch that crosses zero;
- the extreme displacements 0x7FFF and 0x8000;
- a jump whose region bits change because the incremented address carried into bit 28.

The bench's behavioural model also confirms `pc_plus4_o` on every cycle.

// File: rtl/pnu_pkg.sv
`timescale 1ns/1ps
package pnu_pkg;
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } next_src_e;
endpackage

// File: rtl/pnu_incr.sv
`timescale 1ns/1ps
module pnu_incr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] pc4_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    assign pc4_o = pc_i + STEP;
endmodule

// File: rtl/pnu_branch_calc.sv
`timescale 1ns/1ps
module pnu_branch_calc #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int EXT_W = ADDR_W - IMM_W - 2;

    logic [ADDR_W-1:0] byte_offset;

    // word displacement, sign-extended and scaled to bytes
    assign byte_offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
    assign tgt_o       = base_i + byte_offset;
endmodule

// File: rtl/pnu_jump_calc.sv
`timescale 1ns/1ps
module pnu_jump_calc #(
    parameter int ADDR_W = 32,
    parameter int TGT_W  = 26
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [TGT_W-1:0]  field_i,
    output logic [ADDR_W-1:0] tgt_o
);
    localparam int REGION_W = ADDR_W - TGT_W - 2;

    assign tgt_o = {base_i[ADDR_W-1 -: REGION_W], field_i, 2'b00};
endmodule

// File: rtl/pnu_src_sel.sv
`timescale 1ns/1ps
module pnu_src_sel
    import pnu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              br_sel_i,
    input  logic              jmp_sel_i,
    input  logic              eq_i,
    input  logic [ADDR_W-1:0] seq_addr_i,
    input  logic [ADDR_W-1:0] br_addr_i,
    input  logic [ADDR_W-1:0] jmp_addr_i,
    output logic [ADDR_W-1:0] next_o
);
    next_src_e src;

    // decision: jump outranks a taken branch
    always_comb begin
        if (jmp_sel_i)
            src = SRC_JUMP;
        else if (br_sel_i && eq_i)
            src = SRC_BRANCH;
        else
            src = SRC_SEQ;
    end

    // output mux
    always_comb begin
        unique case (src)
            SRC_JUMP:   next_o = jmp_addr_i;
            SRC_BRANCH: next_o = br_addr_i;
            SRC_SEQ:    next_o = seq_addr_i;
            default:    next_o = seq_addr_i;
        endcase
    end
endmodule

// File: rtl/pc_next_unit.sv
`timescale 1ns/1ps
module pc_next_unit #(
    parameter int                ADDR_W     = 32,
    parameter int                IMM_W      = 16,
    parameter int                TGT_W      = 26,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [TGT_W-1:0]  jtgt_i,
    input  logic              br_sel_i,
    input  logic              jmp_sel_i,
    input  logic              alu_eq_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_plus4_o
);
    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] seq_addr;
    logic [ADDR_W-1:0] br_addr;
    logic [ADDR_W-1:0] jmp_addr;
    logic [ADDR_W-1:0] next_addr;

    pnu_incr #(.ADDR_W(ADDR_W)) incr_i (
        .pc_i  (pc_q),
        .pc4_o (seq_addr)
    );

    pnu_branch_calc #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) brc_i (
        .base_i (seq_addr),
        .imm_i  (imm_i),
        .tgt_o  (br_addr)
    );

    pnu_jump_calc #(.ADDR_W(ADDR_W), .TGT_W(TGT_W)) jmc_i (
        .base_i  (seq_addr),
        .field_i (jtgt_i),
        .tgt_o   (jmp_addr)
    );

    pnu_src_sel #(.ADDR_W(ADDR_W)) sel_i (
        .br_sel_i   (br_sel_i),
        .jmp_sel_i  (jmp_sel_i),
        .eq_i       (alu_eq_i),
        .seq_addr_i (seq_addr),
        .br_addr_i  (br_addr),
        .jmp_addr_i (jmp_addr),
        .next_o     (next_addr)
    );

    // counter register: loads every edge, no enable
    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= START_ADDR;
        else
            pc_q <= next_addr;
    end

    assign pc_o       = pc_q;
    assign pc_plus4_o = seq_addr;
endmodule

// File: rtl/pc_next_unit_chk.sv
`timescale 1ns/1ps
module pc_next_unit_chk #(
    parameter int                ADDR_W     = 32,
    parameter int                IMM_W      = 16,
    parameter int                TGT_W      = 26,
    parameter logic [ADDR_W-1:0] START_ADDR = '0
) (
    input logic              clk,
    input logic              rst,
    input logic [IMM_W-1:0]  imm_i,
    input logic [TGT_W-1:0]  jtgt_i,
    input logic              br_sel_i,
    input logic              jmp_sel_i,
    input logic              alu_eq_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] pc_plus4_o
);
    localparam int EXT_W    = ADDR_W - IMM_W - 2;
    localparam int REGION_W = ADDR_W - TGT_W - 2;

    p_reset_load_r1: assert property (@(posedge clk)
        rst |=> pc_o == START_ADDR);

    p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!jmp_sel_i && !(br_sel_i && alu_eq_i)) |=> pc_o == $past(pc_o) + ADDR_W'(4));

    p_branch_taken_r4: assert property (@(posedge clk) disable iff (rst)
        (!jmp_sel_i && br_sel_i && alu_eq_i) |=>
            pc_o == $past(pc_o) + ADDR_W'(4)
                    + {{EXT_W{$past(imm_i[IMM_W-1])}}, $past(imm_i), 2'b00});

    // jump wins over a taken branch (R7) and takes region bits from pc+4
    p_jump_prio_r6: assert property (@(posedge clk) disable iff (rst)
        jmp_sel_i |=>
            pc_o == {$past(pc_plus4_o[ADDR_W-1 -: REGION_W]), $past(jtgt_i), 2'b00});

    p_aligned_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> pc_o[1:0] == 2'b00);
endmodule

bind pc_next_unit pc_next_unit_chk #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .TGT_W(TGT_W), .START_ADDR(START_ADDR)
) chk_i (.*);

// File: tb/pc_next_unit_tb_top.sv
`timescale 1ns/1ps
module pc_next_unit_tb_top;
    localparam logic [31:0] START = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imm = '0;
    logic [25:0] tgt = '0;
    logic        br = 1'b0, jmp = 1'b0, eq = 1'b0;
    logic [31:0] pc, pc4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [31:0] exp_pc = 32'h0;

    always #4 clk = ~clk;  // 125 MHz

    pc_next_unit #(.START_ADDR(START)) dut_i (
        .clk(clk), .rst(rst), .imm_i(imm), .jtgt_i(tgt),
        .br_sel_i(br), .jmp_sel_i(jmp), .alu_eq_i(eq),
        .pc_o(pc), .pc_plus4_o(pc4)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural next-address model
    function automatic logic [31:0] model_next(input logic [31:0] cur);
        int off;
        if (rst) return START;
        if (jmp) return ((cur + 32'd4) & 32'hF000_0000) | (32'(tgt) << 2);
        if (br && eq) begin
            off = int'($signed(imm));
            return cur + 32'd4 + 32'(off * 4);
        end
        return cur + 32'd4;
    endfunction

    // drive one cycle at a falling edge, compare at the next falling edge
    task automatic step(input logic [15:0] i, input logic [25:0] t, input logic b,
                        input logic j, input logic e, input logic r, input string req);
        rst = r; imm = i; tgt = t; br = b; jmp = j; eq = e;
        #1;
        check("R2 pc_plus4", pc4, pc + 32'd4);
        exp_pc = model_next(pc);
        @(posedge clk);
        @(negedge clk);
        check(req, pc, exp_pc);
        check("R9 alignment", {30'd0, pc[1:0]}, 32'd0);
    endtask

    initial begin
        @(negedge clk);
        step(16'h1234, 26'h1, 1, 1, 1, 1, "R1 reset load");
        step(16'hFFFF, 26'h2, 1, 0, 1, 1, "R1 reset held");
        step(16'h0, 26'h0, 0, 0, 0, 0, "R3 sequential");
        step(16'h0, 26'h0, 0, 0, 1, 0, "R3 eq ignored without branch");
        step(16'h0050, 26'h0, 0, 0, 1, 0, "R3 sequential again");
        step(16'h0050, 26'h0, 1, 0, 0, 0, "R5 branch not taken");
        step(16'h0005, 26'h0, 1, 0, 1, 0, "R4 branch forward");
        step(16'hFFFD, 26'h0, 1, 0, 1, 0, "R4 branch backward");
        step(16'h7FFF, 26'h0, 1, 0, 1, 0, "R4 max displacement");
        step(16'h8000, 26'h0, 1, 0, 1, 0, "R4 min displacement");
        step(16'h0, 26'h0ABCDE, 0, 1, 0, 0, "R6 jump");
        step(16'h0010, 26'h0000123, 1, 1, 1, 0, "R7 jump over taken branch");
        step(16'h0, 26'h0, 0, 1, 0, 0, "R6 jump to zero");
        step(16'hFFFE, 26'h0, 1, 0, 1, 0, "R8 backward branch across zero");
        step(16'h0, 26'h0, 0, 0, 0, 0, "R8 sequential wrap");
        step(16'hFFFE, 26'h0, 1, 0, 1, 0, "R8 wrap again");
        step(16'h0, 26'h3FFFFFF, 0, 1, 0, 0, "R6 region from pc_plus4");
        step(16'h0, 26'h0, 0, 0, 0, 1, "R1 reset mid run");
        step(16'h0, 26'h0, 0, 0, 0, 0, "R3 after reset");
        for (int k = 0; k < 40; k++)
            step(16'(k * 977), 26'(k * 40503), 1'(k % 3 == 0), 1'(k % 7 == 0),
                 1'(k % 2 == 0), 0, "R4 mixed pattern");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule